// File: doc/BRIEF.md
# Acquisition arm controller

This block is the top-level control of a multi-channel charge acquisition unit. It holds the unit in one of two states. In the ready state the conversion logic is kept cleared and waits for a gate. In the busy state the unit holds data, and the readout datapath works on it. A gate can come from the front panel or from a host test command that opens the gate internally. The block tells the conversion logic when to start, and it learns from two done pulses when conversion and readout have finished.

The block also owns the host's path to the configuration register and the per-channel pedestal memory. The host may read or write either one only while the unit is ready. While the unit is busy, every host request is refused and flagged. An initialise command returns the configuration register to its default word at any time.

Top module: `acq_arm_ctrl`

## Requirements
- R1: After synchronous reset the unit is ready: `busy`=0, `conv_clr`=1, `conv_start`=0, `test_run`=0, `acq_complete`=0, `host_ack`=`host_nak`=0, `host_rdata`=0, and `cfg_q` holds the default word 0xF800 (command bits 15:11 set, all other bits clear).
- R2: A `clr` pulse puts the unit in the ready state on the next cycle, from either state. It drops `acq_complete` and `test_run` and raises `conv_clr`. When `clr` and a gate arrive in the same cycle, the clear wins and no `conv_start` is issued.
- R3: In the ready state, `ext_gate` or `test_cmd` moves the unit to busy on the next cycle. At that edge `conv_start` pulses high for exactly one cycle. `test_run` goes high only when `test_cmd` was present in that cycle.
- R4: A gate or test command that arrives while the unit is busy is ignored: no `conv_start`, and the unit stays busy.
- R5: While busy, `acq_complete` rises once both `conv_done` and `ro_done` have been seen, in either order or in the same cycle. The unit stays busy after that until a clear.
- R6: `conv_done` and `ro_done` pulses that arrive while the unit is ready have no effect on the next acquisition.
- R7: While ready, a host request with `host_sel`=0 targets the configuration register. The request is acknowledged by a one-cycle `host_ack` on the next cycle. A read presents the register value on `host_rdata` in the same cycle as the ack.
- R8: While ready, a host request with `host_sel`=1 reads or writes the pedestal word at `host_addr`, using the low 8 bits of the data. A read returns the word on `host_rdata` bits 7:0 with the upper bits zero, together with `host_ack`.
- R9: While busy, any host request gets a one-cycle `host_nak` on the next cycle and no `host_ack`. It changes neither storage nor `host_rdata`.
- R10: `init_cmd` loads 0xF800 into the configuration register on the next cycle, in either state. It wins over a host write in the same cycle.
- R11: When `host_wr` and `host_rd` are both high, the request is treated as a write only: the write takes effect and `host_rdata` is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Clear pulse (front panel or host) |
| ext_gate | input | 1 | Front-panel gate |
| test_cmd | input | 1 | Host test command acting as an internal gate |
| init_cmd | input | 1 | Host initialise command for the configuration register |
| conv_done | input | 1 | Conversion finished pulse |
| ro_done | input | 1 | Readout finished pulse |
| host_wr | input | 1 | Host write request |
| host_rd | input | 1 | Host read request |
| host_sel | input | 1 | Target: 0 configuration register, 1 pedestal memory |
| host_addr | input | 4 | Pedestal channel address |
| host_wdata | input | 16 | Host write data |
| busy | output | 1 | Unit is in the busy state |
| conv_clr | output | 1 | Conversion logic held cleared (ready state) |
| conv_start | output | 1 | One-cycle start pulse on gate acceptance |
| test_run | output | 1 | Current acquisition was opened by the test command |
| acq_complete | output | 1 | Conversion and readout both done |
| cfg_q | output | 16 | Configuration register contents |
| host_ack | output | 1 | Host request accepted |
| host_nak | output | 1 | Host request refused (busy) |
| host_rdata | output | 16 | Host read data |

## Verification
The assertions assume that every control input is sampled synchronously, and that the done pulses and host requests are single-cycle strobes whose level carries no meaning beyond the cycle they are high in. The bench drives every input on the falling edge and holds each one for exactly one cycle before it drops it. It never leaves a host request raised across two edges, so every ack or nak it sees belongs to one request. The scenarios cover both states before and after each transition, so each path the properties guard is exercised.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic {
    ST_READY = 1'b0,
    ST_BUSY  = 1'b1
  } acq_st_e;

  typedef enum logic {
    TGT_CFG = 1'b0,
    TGT_PED = 1'b1
  } host_tgt_e;
endpackage

// File: rtl/acq_fsm.sv
module acq_fsm
  import acq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    clr,
  input  logic    ext_gate,
  input  logic    test_cmd,
  input  logic    conv_done,
  input  logic    ro_done,
  output acq_st_e st_q,
  output logic    conv_start_q,
  output logic    test_run_q,
  output logic    complete
);
  logic conv_seen_q, ro_seen_q;
  logic gate_any;

  assign gate_any = ext_gate | test_cmd;
  assign complete = conv_seen_q & ro_seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_READY;
      conv_start_q <= 1'b0;
      test_run_q   <= 1'b0;
      conv_seen_q  <= 1'b0;
      ro_seen_q    <= 1'b0;
    end else begin
      conv_start_q <= 1'b0;
      if (clr) begin
        st_q        <= ST_READY;
        test_run_q  <= 1'b0;
        conv_seen_q <= 1'b0;
        ro_seen_q   <= 1'b0;
      end else if (st_q == ST_READY) begin
        if (gate_any) begin
          st_q         <= ST_BUSY;
          conv_start_q <= 1'b1;
          test_run_q   <= test_cmd;
        end
      end else begin
        if (conv_done) conv_seen_q <= 1'b1;
        if (ro_done)   ro_seen_q   <= 1'b1;
      end
    end
  end

  // R2
  clr_ready_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (st_q == ST_READY && !conv_start_q && !complete));

  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_BUSY && !clr) |=> (st_q == ST_BUSY && !conv_start_q));

  // R3
  start_from_ready_chk: assert property (@(posedge clk) disable iff (rst)
    conv_start_q |-> ($past(st_q) == ST_READY && st_q == ST_BUSY));

  // R5
  complete_busy_chk: assert property (@(posedge clk) disable iff (rst)
    complete |-> st_q == ST_BUSY);
endmodule

// File: rtl/cfg_store.sv
module cfg_store #(
  parameter int          CFG_W    = 16,
  parameter logic [15:0] CFG_INIT = 16'hF800
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic             we,
  input  logic             re,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg_q,
  output logic [CFG_W-1:0] rd_q
);
  localparam logic [CFG_W-1:0] DEFAULT_WORD = CFG_W'(CFG_INIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= DEFAULT_WORD;
      rd_q  <= '0;
    end else begin
      if (init)    cfg_q <= DEFAULT_WORD;
      else if (we) cfg_q <= wdata;
      if (re)      rd_q  <= cfg_q;
    end
  end

  // R10
  init_default_chk: assert property (@(posedge clk) disable iff (rst)
    init |=> cfg_q == DEFAULT_WORD);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!init && !we) |=> $stable(cfg_q));
endmodule

// File: rtl/ped_ram.sv
module ped_ram #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rd_q
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rd_q <= '0;
    else if (re) rd_q <= mem[addr];
  end
endmodule

// File: rtl/acq_arm_ctrl.sv
module acq_arm_ctrl
  import acq_pkg::*;
#(
  parameter int          N_PED    = 16,
  parameter int          PED_W    = 8,
  parameter int          DATA_W   = 16,
  parameter logic [15:0] CFG_INIT = 16'hF800,
  localparam int         AW       = $clog2(N_PED)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              ext_gate,
  input  logic              test_cmd,
  input  logic              init_cmd,
  input  logic              conv_done,
  input  logic              ro_done,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_sel,
  input  logic [AW-1:0]     host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              busy,
  output logic              conv_clr,
  output logic              conv_start,
  output logic              test_run,
  output logic              acq_complete,
  output logic [DATA_W-1:0] cfg_q,
  output logic              host_ack,
  output logic              host_nak,
  output logic [DATA_W-1:0] host_rdata
);
  acq_st_e st;
  logic    req, grant, wr_ok, rd_ok;
  logic    ack_q, nak_q, sel_q;
  logic [DATA_W-1:0] cfg_rd;
  logic [PED_W-1:0]  ped_rd;
  logic [DATA_W-1:0] ped_ext;

  acq_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .clr         (clr),
    .ext_gate    (ext_gate),
    .test_cmd    (test_cmd),
    .conv_done   (conv_done),
    .ro_done     (ro_done),
    .st_q        (st),
    .conv_start_q(conv_start),
    .test_run_q  (test_run),
    .complete    (acq_complete)
  );

  assign req   = host_wr | host_rd;
  assign grant = req & (st == ST_READY);
  assign wr_ok = grant & host_wr;
  assign rd_ok = grant & host_rd & ~host_wr;

  cfg_store #(.CFG_W(DATA_W), .CFG_INIT(CFG_INIT)) u_cfg (
    .clk  (clk),
    .rst  (rst),
    .init (init_cmd),
    .we   (wr_ok & (host_sel == TGT_CFG)),
    .re   (rd_ok & (host_sel == TGT_CFG)),
    .wdata(host_wdata),
    .cfg_q(cfg_q),
    .rd_q (cfg_rd)
  );

  ped_ram #(.DEPTH(N_PED), .W(PED_W)) u_ped (
    .clk  (clk),
    .rst  (rst),
    .we   (wr_ok & (host_sel == TGT_PED)),
    .re   (rd_ok & (host_sel == TGT_PED)),
    .addr (host_addr),
    .wdata(host_wdata[PED_W-1:0]),
    .rd_q (ped_rd)
  );

  generate
    if (DATA_W > PED_W) begin : g_pad
      assign ped_ext = {{(DATA_W-PED_W){1'b0}}, ped_rd};
    end else begin : g_direct
      assign ped_ext = ped_rd;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q <= 1'b0;
      nak_q <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      ack_q <= grant;
      nak_q <= req & (st == ST_BUSY);
      if (rd_ok) sel_q <= host_sel;
    end
  end

  assign busy       = (st == ST_BUSY);
  assign conv_clr   = (st == ST_READY);
  assign host_ack   = ack_q;
  assign host_nak   = nak_q;
  assign host_rdata = sel_q ? ped_ext : cfg_rd;

  // R7
  ack_nak_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(host_ack && host_nak));

  // R9
  nak_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
    host_nak |-> ($past(st) == ST_BUSY && !host_ack));

  // R9
  rdata_hold_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BUSY && !clr) |=> $stable(host_rdata));
endmodule

// File: tb/acq_arm_ctrl_test.sv
`timescale 1ns/1ps
module acq_arm_ctrl_test;
  logic clk = 1'b0;
  logic rst, clr, ext_gate, test_cmd, init_cmd, conv_done, ro_done;
  logic host_wr, host_rd, host_sel;
  logic [3:0]  host_addr;
  logic [15:0] host_wdata;
  logic busy, conv_clr, conv_start, test_run, acq_complete, host_ack, host_nak;
  logic [15:0] cfg_q, host_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  localparam logic [15:0] DEF = 16'hF800;

  always #2 clk = ~clk;

  acq_arm_ctrl uut (
    .clk(clk), .rst(rst), .clr(clr), .ext_gate(ext_gate), .test_cmd(test_cmd),
    .init_cmd(init_cmd), .conv_done(conv_done), .ro_done(ro_done),
    .host_wr(host_wr), .host_rd(host_rd), .host_sel(host_sel),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .busy(busy), .conv_clr(conv_clr), .conv_start(conv_start),
    .test_run(test_run), .acq_complete(acq_complete), .cfg_q(cfg_q),
    .host_ack(host_ack), .host_nak(host_nak), .host_rdata(host_rdata)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) & 255);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    clr = 0; ext_gate = 0; test_cmd = 0; init_cmd = 0; conv_done = 0; ro_done = 0;
    host_wr = 0; host_rd = 0; host_sel = 0; host_addr = '0; host_wdata = '0;
  endtask

  task automatic host_op(input logic wr, input logic rd, input logic sel,
                         input logic [3:0] a, input logic [15:0] d);
    host_wr = wr; host_rd = rd; host_sel = sel; host_addr = a; host_wdata = d;
    tick();
    host_wr = 0; host_rd = 0;
  endtask

  task automatic pulse_clr();
    clr = 1; tick(); clr = 0;
  endtask

  task automatic t_reset();
    chk("R1", "busy", busy, 0);
    chk("R1", "conv_clr", conv_clr, 1);
    chk("R1", "conv_start", conv_start, 0);
    chk("R1", "test_run", test_run, 0);
    chk("R1", "complete", acq_complete, 0);
    chk("R1", "ack/nak", {host_ack, host_nak}, 0);
    chk("R1", "rdata", host_rdata, 0);
    chk("R1", "cfg", cfg_q, DEF);
  endtask

  task automatic t_cfg_rw();
    host_op(1, 0, 0, 0, 16'h1234);
    chk("R7", "write ack", {host_ack, host_nak}, 2'b10);
    chk("R7", "cfg after write", cfg_q, 16'h1234);
    tick();
    chk("R7", "ack single cycle", host_ack, 0);
    host_op(0, 1, 0, 0, 0);
    chk("R7", "read ack", host_ack, 1);
    chk("R7", "read data", host_rdata, 16'h1234);
  endtask

  task automatic t_ped_rw();
    for (int i = 0; i < 16; i++) host_op(1, 0, 1, 4'(i), {8'hA5, pat(i)});
    for (int i = 15; i >= 0; i--) begin
      host_op(0, 1, 1, 4'(i), 0);
      chk("R8", "ped read", {host_ack, host_rdata}, {1'b1, 8'h00, pat(i)});
    end
  endtask

  task automatic t_wr_rd_same();
    host_op(0, 1, 1, 4'd2, 0);
    host_op(1, 1, 1, 4'd5, 16'h00AB);
    chk("R11", "ack", host_ack, 1);
    chk("R11", "rdata unchanged", host_rdata, {8'h00, pat(2)});
    host_op(0, 1, 1, 4'd5, 0);
    chk("R11", "write took effect", host_rdata, 16'h00AB);
  endtask

  task automatic t_gate_ext();
    ext_gate = 1; tick(); ext_gate = 0;
    chk("R3", "busy", busy, 1);
    chk("R3", "conv_start", conv_start, 1);
    chk("R3", "test_run", test_run, 0);
    chk("R3", "conv_clr", conv_clr, 0);
    tick();
    chk("R3", "start one cycle", conv_start, 0);
  endtask

  task automatic t_busy_ignore();
    logic [15:0] prev;
    prev = host_rdata;
    ext_gate = 1; test_cmd = 1; tick(); ext_gate = 0; test_cmd = 0;
    chk("R4", "no start", conv_start, 0);
    chk("R4", "still busy", busy, 1);
    chk("R4", "test_run", test_run, 0);
    host_op(1, 0, 0, 0, 16'h5555);
    chk("R9", "cfg write nak", {host_ack, host_nak}, 2'b01);
    chk("R9", "cfg unchanged", cfg_q, 16'h1234);
    host_op(1, 0, 1, 4'd0, 16'h00EE);
    chk("R9", "ped write nak", {host_ack, host_nak}, 2'b01);
    host_op(0, 1, 0, 0, 0);
    chk("R9", "read nak", {host_ack, host_nak}, 2'b01);
    chk("R9", "rdata unchanged", host_rdata, prev);
    init_cmd = 1; tick(); init_cmd = 0;
    chk("R10", "init while busy", cfg_q, DEF);
  endtask

  task automatic t_done_seq();
    conv_done = 1; tick(); conv_done = 0;
    chk("R5", "conv only", acq_complete, 0);
    ro_done = 1; tick(); ro_done = 0;
    chk("R5", "both done", acq_complete, 1);
    chk("R5", "stays busy", busy, 1);
    ext_gate = 1; tick(); ext_gate = 0;
    chk("R4", "gate after done ignored", {busy, conv_start}, 2'b10);
    pulse_clr();
    chk("R2", "clr ready", {busy, conv_clr, acq_complete}, 3'b010);
    host_op(0, 1, 0, 0, 0);
    chk("R9", "cfg after rejected write", host_rdata, DEF);
    host_op(0, 1, 1, 4'd0, 0);
    chk("R9", "ped after rejected write", host_rdata, {8'h00, pat(0)});
  endtask

  task automatic t_test_gate();
    test_cmd = 1; tick(); test_cmd = 0;
    chk("R3", "test gate", {busy, conv_start, test_run}, 3'b111);
    conv_done = 1; ro_done = 1; tick(); conv_done = 0; ro_done = 0;
    chk("R5", "same-cycle dones", acq_complete, 1);
    pulse_clr();
    chk("R2", "test_run cleared", {busy, test_run, acq_complete}, 3'b000);
  endtask

  task automatic t_clr_prio();
    clr = 1; ext_gate = 1; tick(); clr = 0; ext_gate = 0;
    chk("R2", "clear wins over gate", {busy, conv_start, conv_clr}, 3'b001);
    ext_gate = 1; tick(); ext_gate = 0;
    ro_done = 1; tick(); ro_done = 0;
    clr = 1; test_cmd = 1; tick(); clr = 0; test_cmd = 0;
    chk("R2", "clear from busy with test", {busy, conv_start, test_run, acq_complete}, 4'b0000);
  endtask

  task automatic t_done_in_ready();
    conv_done = 1; ro_done = 1; tick(); conv_done = 0; ro_done = 0;
    chk("R6", "ready ignores done", {busy, acq_complete}, 2'b00);
    ext_gate = 1; tick(); ext_gate = 0;
    chk("R6", "fresh acquisition", acq_complete, 0);
    ro_done = 1; tick(); ro_done = 0;
    chk("R6", "ro only", acq_complete, 0);
    conv_done = 1; tick(); conv_done = 0;
    chk("R5", "reverse order", acq_complete, 1);
    pulse_clr();
  endtask

  task automatic t_init_vs_write();
    host_op(1, 0, 0, 0, 16'h0F0F);
    chk("R7", "cfg write", cfg_q, 16'h0F0F);
    init_cmd = 1; host_wr = 1; host_sel = 0; host_wdata = 16'h3C3C;
    tick();
    init_cmd = 0; host_wr = 0;
    chk("R10", "init beats write", cfg_q, DEF);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1;
    repeat (3) tick();
    rst = 0;
    tick();
    t_reset();
    t_cfg_rw();
    t_ped_rw();
    t_wr_rd_same();
    t_gate_ext();
    t_busy_ignore();
    t_done_seq();
    t_test_gate();
    t_clr_prio();
    t_done_in_ready();
    t_init_vs_write();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule